// File: doc/BRIEF.md
# Maskable Word Trigger Comparator

This block watches a 16-bit word that is registered every system clock and raises an active-high match flag whenever each channel of that word either equals a programmed pattern bit or is excluded by a don't-care bit. A capture controller uses the flag as its trigger condition. The 16 don't-care bits and the 16 pattern bits sit together in one 32-bit configuration register. That register is loaded one bit at a time over a serial data line and a serial shift clock. It has no reset: each new bit pushes the oldest bit out of the far end.

The serial shift clock is asynchronous to the system clock. Both serial lines pass through a synchroniser, and a rising edge of the shift clock becomes a one-cycle shift enable in the system clock domain. While a load is in progress the match flag may be meaningless, so the controller keeps capture disarmed until loading is complete.

A readback path carries the same registered word back to a host one bit per byte. Two 8-to-1 selectors share a 3-bit select. Eight reads with select values 0 to 7 recover all 16 bits.

Top module: `word_trigger_match`

## Requirements
- R1: While reset is asserted, and after it is released but before any system clock edge has registered a new word, both readback bits are 0 for every select value, whatever the word input holds.
- R2: Each rising edge of `cfg_sclk` shifts the level on `cfg_sdata` into the configuration register. After 32 edges, the first 16 bits sent are the don't-care bits for channels 15 down to 0, and the last 16 bits sent are the pattern bits for channels 15 down to 0. Within each half the most significant channel is sent first.
- R3: A channel whose don't-care bit is 0 counts as matched only when its word bit equals its pattern bit. `match` is 1 exactly when every channel counts as matched.
- R4: A channel whose don't-care bit is 1 counts as matched whatever its word bit is.
- R5: When all 16 don't-care bits are 1, `match` is 1 for every word.
- R6: `samp_word` is registered on the rising system clock edge. `match` reflects that registered word, so it changes only after the edge and never directly from `samp_word`.
- R7: `rd_bits[0]` equals bit `rd_sel` of the registered word, and `rd_bits[1]` equals bit `8 + rd_sel`. Both follow `rd_sel` without a clock.
- R8: The configuration register has no reset. Sending more than 32 bits discards the earliest ones, so only the last 32 bits sent decide the configuration.
- R9: Without a rising edge on `cfg_sclk`, changes on `cfg_sdata` leave the configuration, and therefore `match`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sclk | input | 1 | Serial configuration shift clock, asynchronous to clk |
| cfg_sdata | input | 1 | Serial configuration data, sampled at the rising edge of cfg_sclk |
| samp_word | input | 16 | Sampled input word |
| rd_sel | input | 3 | Bit select shared by both readback selectors |
| match | output | 1 | High when every channel matches or is masked |
| rd_bits | output | 2 | One bit from each byte of the registered word |

## Verification
A configuration bit shifted into the wrong position does not show up as a wrong value in a single channel. It appears as a wrong `match` result, and only for words that test that channel, one cycle after such a word is presented. For this reason the bench sweeps every single-bit deviation from each loaded pattern. A readback selector that indexes the wrong bit shows on `rd_bits` straight away for any word whose bytes are not uniform. A shift taken on the wrong edge, or with missed edges, changes the entire configuration after one load and fails almost every pattern check that follows.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  localparam int unsigned WTM_CH_W_DEF   = 16;
  localparam int unsigned WTM_GRP_W_DEF  = 8;
  localparam int unsigned WTM_SYNC_DEF   = 2;
endpackage

// File: rtl/wtm_cfg_sync.sv
module wtm_cfg_sync #(
  parameter int unsigned STAGES = wtm_pkg::WTM_SYNC_DEF
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic rst_n_o,
  output logic shift_en,
  output logic shift_bit
);
  logic [1:0]      rst_ff;
  logic [STAGES:0] sclk_pipe, sclk_pipe_nx;
  logic [STAGES:0] data_pipe, data_pipe_nx;

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_ff <= 2'b00;
    else         rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_o = rst_ff[1];

  always_comb begin
    sclk_pipe_nx = {sclk_pipe[STAGES-1:0], sclk_in};
    data_pipe_nx = {data_pipe[STAGES-1:0], sdata_in};
  end

  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) begin
      sclk_pipe <= '0;
      data_pipe <= '0;
    end else begin
      sclk_pipe <= sclk_pipe_nx;
      data_pipe <= data_pipe_nx;
    end
  end

  // one-cycle enable on a synchronised rising edge of the shift clock
  assign shift_en  = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES];
  assign shift_bit = data_pipe[STAGES-1];
endmodule

// File: rtl/wtm_cfg_shreg.sv
module wtm_cfg_shreg #(
  parameter int unsigned CH_W = wtm_pkg::WTM_CH_W_DEF,
  localparam int unsigned CFG_W = 2 * CH_W
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CH_W-1:0]  dc_bits,
  output logic [CH_W-1:0]  pat_bits
);
  logic [CFG_W-1:0] cfg_nx;

  always_comb begin
    cfg_nx = cfg_q;
    if (shift_en) cfg_nx = {cfg_q[CFG_W-2:0], shift_bit};
  end

  // deliberately without reset: stale bits fall off the far end
  always_ff @(posedge clk) begin
    cfg_q <= cfg_nx;
  end

  assign dc_bits  = cfg_q[CFG_W-1:CH_W];
  assign pat_bits = cfg_q[CH_W-1:0];
endmodule

// File: rtl/wtm_compare.sv
module wtm_compare #(
  parameter int unsigned CH_W = wtm_pkg::WTM_CH_W_DEF
) (
  input  logic [CH_W-1:0] word,
  input  logic [CH_W-1:0] dc_bits,
  input  logic [CH_W-1:0] pat_bits,
  output logic            hit
);
  logic [CH_W-1:0] ch_ok;

  for (genvar i = 0; i < CH_W; i++) begin : g_ch
    assign ch_ok[i] = ~(word[i] ^ pat_bits[i]) | dc_bits[i];
  end

  assign hit = &ch_ok;
endmodule

// File: rtl/wtm_bitsel.sv
module wtm_bitsel #(
  parameter int unsigned CH_W  = wtm_pkg::WTM_CH_W_DEF,
  parameter int unsigned GRP_W = wtm_pkg::WTM_GRP_W_DEF,
  localparam int unsigned NGRP  = CH_W / GRP_W,
  localparam int unsigned SEL_W = $clog2(GRP_W)
) (
  input  logic [CH_W-1:0]  word,
  input  logic [SEL_W-1:0] sel,
  output logic [NGRP-1:0]  bits
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] slice;
    assign slice   = word[g*GRP_W +: GRP_W];
    assign bits[g] = slice[sel];
  end
endmodule

// File: rtl/word_trigger_match.sv
module word_trigger_match #(
  parameter int unsigned CH_W   = wtm_pkg::WTM_CH_W_DEF,
  parameter int unsigned GRP_W  = wtm_pkg::WTM_GRP_W_DEF,
  parameter int unsigned STAGES = wtm_pkg::WTM_SYNC_DEF,
  localparam int unsigned NGRP  = CH_W / GRP_W,
  localparam int unsigned SEL_W = $clog2(GRP_W),
  localparam int unsigned CFG_W = 2 * CH_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cfg_sclk,
  input  logic             cfg_sdata,
  input  logic [CH_W-1:0]  samp_word,
  input  logic [SEL_W-1:0] rd_sel,
  output logic             match,
  output logic [NGRP-1:0]  rd_bits
);
  logic             rst_sync_n;
  logic             shift_en, shift_bit;
  logic [CFG_W-1:0] cfg_q;
  logic [CH_W-1:0]  dc_bits, pat_bits;
  logic [CH_W-1:0]  word_q, word_nx;

  wtm_cfg_sync #(.STAGES(STAGES)) sync_i (
    .clk(clk), .arst_n(arst_n), .sclk_in(cfg_sclk), .sdata_in(cfg_sdata),
    .rst_n_o(rst_sync_n), .shift_en(shift_en), .shift_bit(shift_bit)
  );

  wtm_cfg_shreg #(.CH_W(CH_W)) shreg_i (
    .clk(clk), .shift_en(shift_en), .shift_bit(shift_bit),
    .cfg_q(cfg_q), .dc_bits(dc_bits), .pat_bits(pat_bits)
  );

  assign word_nx = samp_word;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) word_q <= '0;
    else         word_q <= word_nx;
  end

  wtm_compare #(.CH_W(CH_W)) cmp_i (
    .word(word_q), .dc_bits(dc_bits), .pat_bits(pat_bits), .hit(match)
  );

  wtm_bitsel #(.CH_W(CH_W), .GRP_W(GRP_W)) rb_i (
    .word(word_q), .sel(rd_sel), .bits(rd_bits)
  );
endmodule

// File: rtl/wtm_checker.sv
module wtm_checker #(
  parameter int unsigned CH_W  = 16,
  parameter int unsigned GRP_W = 8,
  localparam int unsigned NGRP  = CH_W / GRP_W,
  localparam int unsigned SEL_W = $clog2(GRP_W),
  localparam int unsigned CFG_W = 2 * CH_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             shift_bit,
  input logic [CFG_W-1:0] cfg,
  input logic [CH_W-1:0]  samp_word,
  input logic [SEL_W-1:0] rd_sel,
  input logic             match,
  input logic [NGRP-1:0]  rd_bits
);
  logic [CH_W-1:0] seen_word;
  logic [CH_W-1:0] dc_v, pat_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_word <= '0;
    else        seen_word <= samp_word;
  end

  assign dc_v  = cfg[CFG_W-1:CH_W];
  assign pat_v = cfg[CH_W-1:0];

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cfg[0] == $past(shift_bit)) && (cfg[CFG_W-1:1] == $past(cfg[CFG_W-2:0]))); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg)); // R9

  AST_ALL_DC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (&dc_v) |-> match); // R5

  AST_MATCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    match == ((((seen_word ^ pat_v) & ~dc_v)) == '0)); // R3

  AST_READBACK_LO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bits[0] == seen_word[rd_sel]); // R7

  AST_READBACK_HI: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bits[NGRP-1] == seen_word[(NGRP-1)*GRP_W + rd_sel]); // R7
endmodule

bind word_trigger_match wtm_checker #(.CH_W(CH_W), .GRP_W(GRP_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .shift_en(shift_en), .shift_bit(shift_bit),
  .cfg(cfg_q), .samp_word(samp_word), .rd_sel(rd_sel), .match(match),
  .rd_bits(rd_bits)
);

// File: tb/word_trigger_match_tb.sv
`timescale 1ns/1ps
module word_trigger_match_tb_top;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        cfg_sclk, cfg_sdata;
  logic [15:0] samp_word;
  logic [2:0]  rd_sel;
  logic        match;
  logic [1:0]  rd_bits;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  word_trigger_match dut_i (
    .clk(clk), .arst_n(arst_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .samp_word(samp_word), .rd_sel(rd_sel), .match(match), .rd_bits(rd_bits)
  );

  function automatic logic exp_match(logic [15:0] w, logic [15:0] m, logic [15:0] p);
    return (((w ^ p) & ~m) == 16'h0);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); cfg_sdata = b;
    repeat (3) @(negedge clk); cfg_sclk = 1'b1;
    repeat (4) @(negedge clk); cfg_sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // don't-care bits ch15..ch0 first, then pattern bits ch15..ch0
  task automatic load_cfg(logic [15:0] m, logic [15:0] p);
    logic [31:0] v;
    v = {m, p};
    for (int i = 31; i >= 0; i--) send_bit(v[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic try_word(string req, logic [15:0] w, logic [15:0] m, logic [15:0] p);
    @(negedge clk); samp_word = w;
    @(negedge clk);
    chk(req, {15'h0, match}, {15'h0, exp_match(w, m, p)});
  endtask

  task automatic sweep(string req, logic [15:0] m, logic [15:0] p);
    try_word(req, p, m, p);
    for (int i = 0; i < 16; i++) try_word(req, p ^ (16'h1 << i), m, p);
    for (int k = 0; k < 24; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      // mostly near the pattern, sometimes far away
      try_word(req, (k % 3 == 0) ? seed[31:16] : (p ^ (seed[31:16] & m)), m, p);
    end
  endtask

  task automatic readback(logic [15:0] w);
    @(negedge clk); samp_word = w;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      chk("R7", {14'h0, rd_bits}, {14'h0, w[8+s], w[s]});
    end
  endtask

  initial begin
    arst_n = 1'b0; cfg_sclk = 1'b0; cfg_sdata = 1'b0;
    samp_word = 16'hFFFF; rd_sel = 3'd0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s); #1;
      chk("R1", {14'h0, rd_bits}, 16'h0);
    end
    samp_word = 16'h0;
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3: plain pattern, no don't-cares
    load_cfg(16'h0000, 16'hA5C3);
    sweep("R3", 16'h0000, 16'hA5C3);
    // R4: upper byte ignored
    load_cfg(16'hFF00, 16'h1234);
    sweep("R4", 16'hFF00, 16'h1234);
    // R2 R4: alternating don't-care bits pin down bit order
    load_cfg(16'h5555, 16'h0F0F);
    sweep("R2", 16'h5555, 16'h0F0F);
    load_cfg(16'h8001, 16'h7FFE);
    sweep("R2", 16'h8001, 16'h7FFE);
    // R5: everything ignored
    load_cfg(16'hFFFF, 16'h0000);
    sweep("R5", 16'hFFFF, 16'h0000);

    // R8: one stray leading bit, then 32 bits; the stray bit is pushed out
    send_bit(1'b1);
    load_cfg(16'h0000, 16'h0000);
    try_word("R8", 16'h0000, 16'h0000, 16'h0000);
    try_word("R8", 16'h8000, 16'h0000, 16'h0000);
    try_word("R8", 16'h0001, 16'h0000, 16'h0000);

    // R9: data toggles without shift clock edges
    load_cfg(16'h00F0, 16'h3C3C);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); cfg_sdata = ~cfg_sdata;
    end
    repeat (4) @(negedge clk);
    sweep("R9", 16'h00F0, 16'h3C3C);

    // R6: match changes only after the clock edge
    load_cfg(16'h0000, 16'hBEEF);
    try_word("R6", 16'hBEEF, 16'h0000, 16'hBEEF);
    @(negedge clk); samp_word = 16'h0000; #1;
    chk("R6", {15'h0, match}, 16'h1);
    @(negedge clk);
    chk("R6", {15'h0, match}, 16'h0);

    // R7: readback under several words
    readback(16'hA55A);
    readback(16'h0180);
    readback(16'hFE7F);
    readback(16'h1234);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule